// File: doc/BRIEF.md
# Serial Sequence Recognizer (Reduced Mealy Machine)

This block watches a one-bit serial stream, one bit per clock cycle, and raises a one-bit flag in the same cycle as a qualifying input bit. Its behaviour is fixed by a seven-state transition and output table. The block is built in the five-state form that is equivalent to that table. Two states are equivalent when, for every input bit, they give the same output and move to the same state or to equivalent states. Under that rule two pairs of the original states merge.

The flag is a Mealy output: a combinational function of the present state and the present input bit. A consumer therefore sees it before the clock edge that accepts the bit. A synchronous, active-high reset returns the machine to its start state on the next clock edge.

The five states carry a 3-bit binary code. Their transitions, written as (x=0 / x=1) with the output on x=1 in brackets:
- `S_START` (000): stays in `S_START` / goes to `S_GOT1` [0]
- `S_GOT1` (001): goes to `S_GOT10` / goes to `S_ARMED` [0]
- `S_GOT10` (010): goes to `S_START` / goes to `S_ARMED` [0]
- `S_ARMED` (011): goes to `S_ARMED0` / stays in `S_ARMED` [1]
- `S_ARMED0` (111): goes to `S_START` / goes to `S_ARMED` [1]

The output is 0 in every state when x=0. The three unused codes (100, 101, 110) go to `S_START` on the next clock.

Top module: `seqrec_top`

## Requirements
- R1: On a clock edge with `rst`=1 the machine enters `S_START`. After reset is released, an input of 1 gives `z_out`=0, and the following state is `S_GOT1`.
- R2: `z_out` is 0 in every cycle in which `x_in` is 0, whatever the state.
- R3: In `S_START`, x=0 keeps the machine in `S_START` and x=1 moves it to `S_GOT1`. `z_out` is 0 for both inputs.
- R4: In `S_GOT1`, x=0 moves the machine to `S_GOT10` and x=1 moves it to `S_ARMED`. `z_out` is 0 for both inputs.
- R5: In `S_GOT10`, x=0 moves the machine to `S_START` and x=1 moves it to `S_ARMED`. `z_out` is 0 for both inputs.
- R6: In `S_ARMED`, x=1 keeps the machine in `S_ARMED` with `z_out`=1, and x=0 moves it to `S_ARMED0` with `z_out`=0.
- R7: In `S_ARMED0`, x=1 moves the machine to `S_ARMED` with `z_out`=1, and x=0 moves it to `S_START` with `z_out`=0.
- R8: `z_out` is 1 exactly when `x_in`=1 and the present state is `S_ARMED` or `S_ARMED0`. The output is combinational in the same cycle as the bit.
- R9: On any input stream, `z_out` matches, cycle by cycle, the output of the unreduced seven-state table driven by the same stream and the same resets.
- R10: Reset takes priority over the input. Asserting `rst` in any state with x=1 still gives `S_START` on the next edge. During that reset cycle `z_out` follows the present state and input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to `S_START` |
| x_in | input | 1 | Serial input bit, one per clock cycle |
| z_out | output | 1 | Mealy flag, combinational from the state and `x_in` |

## Verification
The block's only parameter is the state code width, which the package fixes at 3 bits. The bench builds the block with that default, and with it every one of the five states and all ten transitions can be reached from the ports. A vector table walks each transition at least once, including a reset taken from `S_ARMED` with x=1. A long random stream with resets at random times is then compared against an independent seven-state model held in the bench, so the merged states are exercised along every path that leads into them.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        S_START  = 3'b000,
        S_GOT1   = 3'b001,
        S_GOT10  = 3'b010,
        S_ARMED  = 3'b011,
        S_ARMED0 = 3'b111
    } state_t;

endpackage

// File: rtl/seqrec_next_state.sv
module seqrec_next_state
    import seqrec_pkg::*;
(
    input  state_t cur_st,
    input  logic   bit_in,
    output state_t nxt_st
);

    always_comb begin
        unique case (cur_st)
            S_START:  nxt_st = bit_in ? S_GOT1  : S_START;
            S_GOT1:   nxt_st = bit_in ? S_ARMED : S_GOT10;
            S_GOT10:  nxt_st = bit_in ? S_ARMED : S_START;
            S_ARMED:  nxt_st = bit_in ? S_ARMED : S_ARMED0;
            S_ARMED0: nxt_st = bit_in ? S_ARMED : S_START;
            default:  nxt_st = S_START;   // unused codes recover
        endcase
    end

endmodule

// File: rtl/seqrec_output.sv
module seqrec_output
    import seqrec_pkg::*;
(
    input  state_t cur_st,
    input  logic   bit_in,
    output logic   flag
);

    always_comb begin
        unique case (cur_st)
            S_ARMED, S_ARMED0: flag = bit_in;
            S_START, S_GOT1, S_GOT10: flag = 1'b0;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/seqrec_top.sv
module seqrec_top
    import seqrec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);

    state_t state_q;
    state_t state_d;

    seqrec_next_state u_next (
        .cur_st (state_q),
        .bit_in (x_in),
        .nxt_st (state_d)
    );

    // state register: synchronous reset has priority over the input
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_START;
        else     state_q <= state_d;
    end

    seqrec_output u_out (
        .cur_st (state_q),
        .bit_in (x_in),
        .flag   (z_out)
    );

endmodule

// File: rtl/seqrec_chk.sv
module seqrec_chk
    import seqrec_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   x_in,
    input logic   z_out,
    input state_t st
);

    // R1
    reset_start_chk: assert property (@(posedge clk) rst |=> st == S_START);

    // R2
    zero_in_chk: assert property (@(posedge clk) disable iff (rst) !x_in |-> !z_out);

    // R8
    armed_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (x_in && (st == S_ARMED || st == S_ARMED0)) |-> z_out);

    // R3
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_START && !x_in) |=> st == S_START);

    // R4
    got1_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_GOT1 && x_in) |=> st == S_ARMED);

    // R6
    armed_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARMED && x_in) |=> st == S_ARMED);

    // R7
    armed0_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARMED0 && !x_in) |=> st == S_START);

    // R8
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        st inside {S_START, S_GOT1, S_GOT10, S_ARMED, S_ARMED0});

endmodule

bind seqrec_top seqrec_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .z_out (z_out),
    .st    (state_q)
);

// File: tb/sim_seqrec_top.sv
module sim_seqrec_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    seqrec_top u0 (.clk(clk), .rst(rst), .x_in(x_in), .z_out(z_out));

    // vector: {rst, x, expected z}
    localparam int NVEC = 20;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b010,  // R1 start, x=1 -> got1
        3'b000,  // R4 got1 x=0 -> got10
        3'b000,  // R5 got10 x=0 -> start
        3'b000,  // R3 start x=0 -> start
        3'b010,  // R3 start x=1 -> got1
        3'b010,  // R4 got1 x=1 -> armed
        3'b011,  // R6 armed x=1 -> armed, z=1
        3'b000,  // R6 armed x=0 -> armed0
        3'b011,  // R7 armed0 x=1 -> armed, z=1
        3'b000,  // R2 armed x=0 -> armed0
        3'b000,  // R7 armed0 x=0 -> start
        3'b010,  // R8 start x=1 z=0 -> got1
        3'b000,  // R4 got1 x=0 -> got10
        3'b010,  // R5 got10 x=1 -> armed
        3'b011,  // R8 armed x=1 z=1
        3'b111,  // R10 reset in armed, x=1: z follows armed
        3'b010,  // R10 start after reset, z=0 -> got1
        3'b010,  // R8 got1 x=1 z=0 -> armed
        3'b000,  // R2 armed x=0 z=0 -> armed0
        3'b011   // R8 armed0 x=1 z=1
    };
    localparam int VREQ [NVEC] = '{1,4,5,3,3,4,6,6,7,2,7,8,4,5,8,10,10,8,2,8};

    // unreduced seven-state reference, indices 0..6
    function automatic int ref_next(int s, logic x);
        case (s)
            0: return x ? 1 : 0;
            1: return x ? 3 : 2;
            2: return x ? 3 : 0;
            3: return x ? 5 : 4;
            4: return x ? 5 : 0;
            5: return x ? 5 : 6;
            default: return x ? 5 : 0;
        endcase
    endfunction

    function automatic logic ref_out(int s, logic x);
        return x && (s >= 3);
    endfunction

    task automatic check(string tag, logic expz);
        checks++;
        if (z_out !== expz) begin
            errors++;
            $display("FAIL %s: z_out=%0b expected=%0b at %0t", tag, z_out, expz, $time);
        end
    endtask

    task automatic drive(logic r, logic x);
        @(negedge clk);
        rst = r;
        x_in = x;
        #5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        int rs;
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][2], VEC[i][1]);
            check($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][0]);
        end

        // directed: long reset with x=1 holds start, R10
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        check("R10 start after held reset", 1'b0);
        drive(1'b0, 1'b1);
        check("R4 got1 after held reset", 1'b0);
        drive(1'b0, 1'b0);
        check("R2 armed with x=0", 1'b0);
        drive(1'b0, 1'b1);
        check("R7 armed0 x=1", 1'b1);

        // random equivalence against the seven-state table, R9
        drive(1'b1, 1'b0);
        rs = 0;
        for (int i = 0; i < 10000; i++) begin
            logic r, x, e;
            r = ($urandom_range(63) == 0);
            x = $urandom_range(1);
            drive(r, x);
            e = ref_out(rs, x);
            check("R9 random equivalence", e);
            rs = r ? 0 : ref_next(rs, x);
        end
        finish_run();
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule